// File: doc/BRIEF.md
# Power-up initialization sequencer

This block takes a sensor chip from the moment its supplies come up to the point where acceleration results may be handed out. It holds the chip's internal reset until three supply-good indications are all true at once. Once released, it either enters a factory-test state, when the programming-voltage-high indication is set, or runs a two-phase initialization. In the first phase it powers the fuse array and copies every fuse word into a mirror register file. It then removes fuse power and waits out the rest of the phase's time. In the second phase it waits for the sensor reference to settle and, when the high-pass-filter select bit is set, keeps the filter in initialization for a longer interval.

Downstream logic reads three permission outputs. `spi_resp_en` says whether the serial interface may answer at all. `accel_valid` says whether acceleration requests may return real data, rather than a non-acceleration response. `init_busy` feeds the status register bit that shows initialization is still running. Phase durations are cycle counts set by parameters, so real-time values (about 800 µs, 3 ms and 200 ms) are set for the real clock and short ones are used in simulation. If any supply-good input drops, in any state, the block returns to reset and starts the whole sequence again.

Top module: `pwrup_init_seq`

## Requirements
- R1: While `rst_n` is low, or any of `sup_ok_core`, `sup_ok_dig`, `sup_ok_ana` is low, `internal_rst` and `init_busy` are 1, and `spi_resp_en`, `accel_valid`, `fuse_pwr_en`, `hpf_init` and `test_mode` are 0. Two supplies good out of three do not release reset.
- R2: On the edge that releases reset, if `prog_hv` is 1 the block enters test mode (`test_mode`=1, `init_busy`=1, `spi_resp_en`=0, `accel_valid`=0, `fuse_pwr_en`=0) and stays there. Otherwise it enters phase one.
- R3: In phase one, `fuse_pwr_en` is 1. The block issues a one-cycle `fuse_rd` strobe for each fuse address from 0 up to NUM_WORDS-1 in ascending order, one strobe per word. It waits for `fuse_vld` before storing `fuse_data` at that address in the mirror, which is readable through `mir_rd_addr`/`mir_rd_data`.
- R4: `fuse_pwr_en` drops once the last word is stored and stays 0 afterwards. `spi_resp_en` stays 0 for the whole of phase one.
- R5: Phase one lasts exactly PH1_CYC cycles, counted from the fall of `internal_rst` to the rise of `spi_resp_en`, when the copy finishes in time. A slower copy extends the phase, and `spi_resp_en` then rises one cycle after `fuse_pwr_en` falls.
- R6: In phase two, `spi_resp_en`=1 and `accel_valid`=0. Phase two lasts PH2_SHORT_CYC cycles if `hpf_sel` was 0 on entry to the phase, and PH2_LONG_CYC cycles if it was 1.
- R7: `hpf_init` is 1 during every cycle of phase two when `hpf_sel` was 1 on entry to the phase, and is 0 at all other times.
- R8: `init_busy` is 1 from any reset until phase two completes, and only then goes to 0.
- R9: A drop of any supply-good input in any state sets `internal_rst` on the next clock edge. Restoring the supply reruns the full sequence, including a fresh fuse copy.
- R10: In normal mode, `accel_valid`=1, `spi_resp_en`=1 and `init_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_ok_core | input | 1 | Core supply good (synchronized upstream) |
| sup_ok_dig | input | 1 | Digital regulator good |
| sup_ok_ana | input | 1 | Analog regulator good |
| prog_hv | input | 1 | Programming voltage above supply; selects test mode at release |
| hpf_sel | input | 1 | High-pass filter select from configuration |
| fuse_pwr_en | output | 1 | Fuse array power enable |
| fuse_rd | output | 1 | One-cycle fuse word read strobe |
| fuse_addr | output | ADDR_W | Fuse word address |
| fuse_data | input | DATA_W | Fuse word read data |
| fuse_vld | input | 1 | Fuse read data valid |
| mir_rd_addr | input | ADDR_W | Mirror register read address |
| mir_rd_data | output | DATA_W | Mirror register read data |
| internal_rst | output | 1 | Internal reset to the rest of the chip |
| init_busy | output | 1 | Initialization-in-progress status bit |
| spi_resp_en | output | 1 | Serial interface may answer accesses |
| accel_valid | output | 1 | Acceleration results are valid |
| hpf_init | output | 1 | High-pass filter initialization active |
| test_mode | output | 1 | Factory-test state |

## Verification
The bench measures phase lengths to the exact cycle, for both filter settings. An off-by-one in the phase counter, or a filter bit read at the wrong time, shows up as a phase one cycle long or short, or as the short duration used where the long one was selected. A slow fuse model makes the copy outlast the phase-one timer. A design that ends phase one on the timer alone would then open the serial interface with the fuse array still powered, and leave the mirror partly written. It also checks that partial supply combinations keep the chip in reset. Finally, it drops a supply in the middle of phase two and checks for an immediate reset and a full recopy with new fuse contents, which catches a design that latches readiness or skips the copy on restart.

// File: rtl/pwrup_pkg.sv
// Shared types for the power-up initialization sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwrup_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_P1_COPY = 3'd1,
        ST_P1_WAIT = 3'd2,
        ST_P2      = 3'd3,
        ST_NORMAL  = 3'd4,
        ST_FTEST   = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        CP_REQ  = 2'd0,
        CP_WAIT = 2'd1,
        CP_DONE = 2'd2
    } copy_state_t;

    // Largest of three cycle counts, used to size the phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/supply_gate.sv
// Combines several supply-good indications into one "all good" flag.
// Assumes: inputs are already synchronized to clk by the caller.
module supply_gate #(
    parameter int NUM_SUP = 3
) (
    input  logic [NUM_SUP-1:0] ok_vec,
    output logic               all_ok
);

    // All supplies must be good at the same time.
    always_comb begin
        all_ok = &ok_vec;
    end

endmodule

// File: rtl/phase_timer.sv
// Up-counter that times one initialization phase.
// Assumes: limit >= 1; clear takes priority and restarts at zero;
// done is high in the last cycle of a phase of `limit` cycles, and the
// count saturates there.
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Terminal count reached.
    always_comb begin
        done = (cnt == limit - CNT_W'(1));
    end

    // Count cycles while running, holding at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fuse_copier.sv
// Walks fuse word addresses in ascending order, issues a one-cycle read
// strobe per word, waits for the valid handshake and writes the word into
// the mirror register file, which it also owns.
// Assumes: en stays high for the whole copy; dropping en restarts at word 0.
module fuse_copier
    import pwrup_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_vld,
    output logic              copy_done,
    input  logic [ADDR_W-1:0] mir_addr,
    output logic [DATA_W-1:0] mir_data
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

    copy_state_t       cst;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic              wr_en;

    // Handshake decode for strobe, write and completion.
    always_comb begin
        rd_stb    = en && (cst == CP_REQ);
        rd_addr   = addr_q;
        wr_en     = en && (cst == CP_WAIT) && rd_vld;
        copy_done = (cst == CP_DONE);
        mir_data  = mem[mir_addr];
    end

    // Copy state machine and address walker.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cst    <= CP_REQ;
            addr_q <= '0;
        end else begin
            case (cst)
                CP_REQ:  cst <= CP_WAIT;
                CP_WAIT: if (rd_vld) begin
                    if (addr_q == LAST_ADDR) begin
                        cst <= CP_DONE;
                    end else begin
                        cst    <= CP_REQ;
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                end
                default: cst <= CP_DONE;
            endcase
        end
    end

    // Mirror register file, one word per fuse address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr_q] <= rd_data;
        end
    end

endmodule

// File: rtl/pwrup_init_seq.sv
// Power-up initialization sequencer: holds internal reset until all supplies
// are good, then runs fuse-copy phase one and settle phase two, or enters
// factory test when the programming voltage is high at release.
// Assumes: supply-good and prog_hv inputs are synchronized upstream; the
// cycle-count parameters are at least 1.
module pwrup_init_seq
    import pwrup_pkg::*;
#(
    parameter int NUM_WORDS     = 16,
    parameter int DATA_W        = 16,
    parameter int PH1_CYC       = 100_000,
    parameter int PH2_SHORT_CYC = 375_000,
    parameter int PH2_LONG_CYC  = 25_000_000,
    localparam int ADDR_W       = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_ok_core,
    input  logic              sup_ok_dig,
    input  logic              sup_ok_ana,
    input  logic              prog_hv,
    input  logic              hpf_sel,
    output logic              fuse_pwr_en,
    output logic              fuse_rd,
    output logic [ADDR_W-1:0] fuse_addr,
    input  logic [DATA_W-1:0] fuse_data,
    input  logic              fuse_vld,
    input  logic [ADDR_W-1:0] mir_rd_addr,
    output logic [DATA_W-1:0] mir_rd_data,
    output logic              internal_rst,
    output logic              init_busy,
    output logic              spi_resp_en,
    output logic              accel_valid,
    output logic              hpf_init,
    output logic              test_mode
);

    localparam int CNT_W = $clog2(max3(PH1_CYC, PH2_SHORT_CYC, PH2_LONG_CYC) + 1);
    localparam logic [CNT_W-1:0] LIM_P1  = CNT_W'(PH1_CYC);
    localparam logic [CNT_W-1:0] LIM_P2S = CNT_W'(PH2_SHORT_CYC);
    localparam logic [CNT_W-1:0] LIM_P2L = CNT_W'(PH2_LONG_CYC);

    seq_state_t       state, nxt;
    logic             sup_all;
    logic             copy_en, copy_done;
    logic             t_clear, t_run, t_done;
    logic [CNT_W-1:0] t_limit;
    logic             hpf_q;

    supply_gate #(.NUM_SUP(3)) u_sup (
        .ok_vec ({sup_ok_core, sup_ok_dig, sup_ok_ana}),
        .all_ok (sup_all)
    );

    fuse_copier #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (copy_en),
        .rd_stb    (fuse_rd),
        .rd_addr   (fuse_addr),
        .rd_data   (fuse_data),
        .rd_vld    (fuse_vld),
        .copy_done (copy_done),
        .mir_addr  (mir_rd_addr),
        .mir_data  (mir_rd_data)
    );

    phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (t_clear),
        .run   (t_run),
        .limit (t_limit),
        .done  (t_done)
    );

    // Next-state decode; any supply loss wins over everything.
    always_comb begin
        nxt = state;
        if (!sup_all) begin
            nxt = ST_RESET;
        end else begin
            case (state)
                ST_RESET:   nxt = prog_hv ? ST_FTEST : ST_P1_COPY;
                ST_P1_COPY: if (copy_done) nxt = ST_P1_WAIT;
                ST_P1_WAIT: if (t_done) nxt = ST_P2;
                ST_P2:      if (t_done) nxt = ST_NORMAL;
                ST_NORMAL:  nxt = ST_NORMAL;
                ST_FTEST:   nxt = ST_FTEST;
                default:    nxt = ST_RESET;
            endcase
        end
    end

    // Phase timer control: restart on entry to each phase, pick its length.
    always_comb begin
        t_clear = ((nxt == ST_P1_COPY) && (state != ST_P1_COPY)) ||
                  ((nxt == ST_P2) && (state != ST_P2));
        t_run   = (state == ST_P1_COPY) || (state == ST_P1_WAIT) || (state == ST_P2);
        t_limit = (state == ST_P2) ? (hpf_q ? LIM_P2L : LIM_P2S) : LIM_P1;
        copy_en = (state == ST_P1_COPY);
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            state <= nxt;
        end
    end

    // Capture the filter select once, on entry to phase two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpf_q <= 1'b0;
        end else if ((nxt == ST_P2) && (state != ST_P2)) begin
            hpf_q <= hpf_sel;
        end
    end

    // Output permissions decoded from the state.
    always_comb begin
        internal_rst = (state == ST_RESET);
        fuse_pwr_en  = (state == ST_P1_COPY);
        spi_resp_en  = (state == ST_P2) || (state == ST_NORMAL);
        accel_valid  = (state == ST_NORMAL);
        init_busy    = (state != ST_NORMAL);
        hpf_init     = (state == ST_P2) && hpf_q;
        test_mode    = (state == ST_FTEST);
    end

endmodule

// File: rtl/pwrup_init_seq_chk.sv
// Assertion checker for the power-up initialization sequencer, bound to the
// top module. Observes ports only.
module pwrup_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_ok_core,
    input logic sup_ok_dig,
    input logic sup_ok_ana,
    input logic fuse_pwr_en,
    input logic fuse_rd,
    input logic internal_rst,
    input logic init_busy,
    input logic spi_resp_en,
    input logic accel_valid,
    input logic hpf_init,
    input logic test_mode
);

    AST_RST_HOLDS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        internal_rst |-> (init_busy && !spi_resp_en && !accel_valid && !fuse_pwr_en)); // R1
    AST_TEST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (!spi_resp_en && !fuse_pwr_en && !accel_valid && init_busy)); // R2
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_rd |=> !fuse_rd); // R3
    AST_STROBE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_rd |-> fuse_pwr_en); // R3
    AST_NO_SPI_IN_P1: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_pwr_en |-> !spi_resp_en); // R4
    AST_HPF_IN_P2_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        hpf_init |-> (spi_resp_en && !accel_valid)); // R7
    AST_BUSY_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy) |-> accel_valid); // R8
    AST_SUPPLY_LOSS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sup_ok_core && sup_ok_dig && sup_ok_ana) |=> internal_rst); // R9
    AST_READY_PERMS: assert property (@(posedge clk) disable iff (!rst_n)
        accel_valid |-> (spi_resp_en && !init_busy)); // R10

endmodule

bind pwrup_init_seq pwrup_init_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_ok_core  (sup_ok_core),
    .sup_ok_dig   (sup_ok_dig),
    .sup_ok_ana   (sup_ok_ana),
    .fuse_pwr_en  (fuse_pwr_en),
    .fuse_rd      (fuse_rd),
    .internal_rst (internal_rst),
    .init_busy    (init_busy),
    .spi_resp_en  (spi_resp_en),
    .accel_valid  (accel_valid),
    .hpf_init     (hpf_init),
    .test_mode    (test_mode)
);

// File: tb/pwrup_init_seq_tb_top.sv
// Directed testbench for the power-up initialization sequencer.
module pwrup_init_seq_tb_top;

    localparam int NW   = 8;
    localparam int DW   = 16;
    localparam int AW   = $clog2(NW);
    localparam int PH1  = 40;
    localparam int PH2S = 20;
    localparam int PH2L = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_ok_core = 1'b0, sup_ok_dig = 1'b0, sup_ok_ana = 1'b0;
    logic          prog_hv = 1'b0, hpf_sel = 1'b0;
    logic          fuse_pwr_en, fuse_rd;
    logic [AW-1:0] fuse_addr;
    logic [DW-1:0] fuse_data = '0;
    logic          fuse_vld = 1'b0;
    logic [AW-1:0] mir_rd_addr = '0;
    logic [DW-1:0] mir_rd_data;
    logic          internal_rst, init_busy, spi_resp_en, accel_valid, hpf_init, test_mode;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int fuse_lat = 0;
    int ord_bad = 0, rd_cnt = 0, exp_addr = 0;
    logic [DW-1:0] seed = 16'hA5C3;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    pwrup_init_seq #(
        .NUM_WORDS(NW), .DATA_W(DW), .PH1_CYC(PH1),
        .PH2_SHORT_CYC(PH2S), .PH2_LONG_CYC(PH2L)
    ) dut_i (.*);

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 291) ^ seed;
    endfunction

    // Fuse array model: answers each strobe after fuse_lat extra cycles.
    initial begin
        bit pend = 1'b0;
        int dly = 0;
        int a_q = 0;
        forever begin
            @(negedge clk);
            fuse_vld = 1'b0;
            if (internal_rst) begin
                exp_addr = 0;
                rd_cnt = 0;
                pend = 1'b0;
            end
            if (pend) begin
                if (dly == 0) begin
                    fuse_vld = 1'b1;
                    fuse_data = pat(a_q);
                    pend = 1'b0;
                end else begin
                    dly--;
                end
            end
            if (fuse_rd) begin
                if (int'(fuse_addr) != exp_addr) ord_bad++;
                exp_addr++;
                rd_cnt++;
                pend = 1'b1;
                dly = fuse_lat;
                a_q = int'(fuse_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic set_sup(input logic a, input logic b, input logic c);
        @(negedge clk);
        sup_ok_core = a;
        sup_ok_dig = b;
        sup_ok_ana = c;
    endtask

    // Reset state with rst_n low.
    task automatic t_reset();
        rst_n = 1'b0;
        sup_ok_core = 1'b1; sup_ok_dig = 1'b1; sup_ok_ana = 1'b1;
        repeat (3) @(negedge clk);
        chk(internal_rst && init_busy && !spi_resp_en && !accel_valid && !fuse_pwr_en
            && !hpf_init && !test_mode, "R1 reset state", int'(internal_rst), 1);
        set_sup(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // Partial supply combinations must not release reset.
    task automatic t_supply_gate();
        logic [2:0] combos [3] = '{3'b011, 3'b101, 3'b110};
        foreach (combos[i]) begin
            set_sup(combos[i][2], combos[i][1], combos[i][0]);
            repeat (5) @(negedge clk);
            chk(internal_rst && !fuse_pwr_en && !spi_resp_en, "R1 partial supplies",
                int'(internal_rst), 1);
        end
        set_sup(1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    // Full sequence with given filter select and fuse latency.
    task automatic run_seq(input bit hpf, input int lat, input bit slow);
        int t_rel = -1, t_foff = -1, t_spi = -1, t_acc = -1;
        int hpf_cyc = 0, spi_in_p1 = 0, busy_bad = 0, guard = 0;
        int p2_exp = hpf ? PH2L : PH2S;
        hpf_sel = hpf;
        fuse_lat = lat;
        prog_hv = 1'b0;
        set_sup(1'b1, 1'b1, 1'b1);
        while (t_acc < 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (t_rel < 0 && !internal_rst) t_rel = cyc;
            if (t_rel >= 0 && t_foff < 0 && !fuse_pwr_en) t_foff = cyc;
            if (t_spi < 0 && spi_resp_en) t_spi = cyc;
            if (t_acc < 0 && accel_valid) t_acc = cyc;
            if (hpf_init) hpf_cyc++;
            if (fuse_pwr_en && spi_resp_en) spi_in_p1++;
            if (t_acc < 0 && !init_busy) busy_bad++;
            if (spi_resp_en && !accel_valid && t_spi >= 0 && (!init_busy)) busy_bad++;
        end
        chk(ord_bad == 0, "R3 ascending addresses", ord_bad, 0);
        chk(rd_cnt == NW, "R3 one strobe per word", rd_cnt, NW);
        for (int i = 0; i < NW; i++) begin
            mir_rd_addr = AW'(i);
            #1;
            chk(mir_rd_data == pat(i), "R3 mirror word", int'(mir_rd_data), int'(pat(i)));
        end
        chk(spi_in_p1 == 0, "R4 no serial response in phase one", spi_in_p1, 0);
        chk(t_foff > t_rel && t_foff <= t_spi, "R4 fuse power off before phase two",
            t_foff, t_spi);
        if (!slow) begin
            chk(t_spi - t_rel == PH1, "R5 phase one length", t_spi - t_rel, PH1);
        end else begin
            chk(t_spi - t_rel > PH1, "R5 phase one extended", t_spi - t_rel, PH1 + 1);
            chk(t_spi - t_foff == 1, "R5 phase two follows copy", t_spi - t_foff, 1);
        end
        chk(t_acc - t_spi == p2_exp, "R6 phase two length", t_acc - t_spi, p2_exp);
        chk(hpf_cyc == (hpf ? p2_exp : 0), "R7 filter init cycles", hpf_cyc, hpf ? p2_exp : 0);
        chk(busy_bad == 0, "R8 busy until phase two ends", busy_bad, 0);
        chk(accel_valid && spi_resp_en && !init_busy && !hpf_init, "R10 normal mode",
            int'(accel_valid), 1);
    endtask

    task automatic t_normal_short(); run_seq(1'b0, 0, 1'b0); endtask
    task automatic t_hpf_long();     run_seq(1'b1, 0, 1'b0); endtask
    task automatic t_slow_fuse();    run_seq(1'b0, 5, 1'b1); endtask

    // Supply loss from normal mode.
    task automatic t_drop_normal();
        set_sup(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk(internal_rst && !accel_valid && init_busy, "R9 reset after loss in normal",
            int'(internal_rst), 1);
        set_sup(1'b0, 1'b0, 1'b0);
    endtask

    // Supply loss mid phase two, then restart with new fuse contents.
    task automatic t_drop_midway();
        hpf_sel = 1'b1;
        fuse_lat = 0;
        set_sup(1'b1, 1'b1, 1'b1);
        while (!spi_resp_en) @(negedge clk);
        repeat (5) @(negedge clk);
        hpf_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk(hpf_init, "R7 select sampled at phase entry", int'(hpf_init), 1);
        chk(spi_resp_en && !accel_valid, "R6 phase two permissions", int'(accel_valid), 0);
        sup_ok_dig = 1'b0;
        @(negedge clk);
        chk(internal_rst && !spi_resp_en && !hpf_init, "R9 reset after loss in phase two",
            int'(internal_rst), 1);
        sup_ok_dig = 1'b1;
        sup_ok_core = 1'b0;
        seed = 16'h3C5A;
        repeat (3) @(negedge clk);
        run_seq(1'b0, 0, 1'b0);
        set_sup(1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    // Programming voltage high at release selects test mode.
    task automatic t_test_mode();
        int leaked = 0;
        prog_hv = 1'b1;
        set_sup(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk(test_mode && !internal_rst, "R2 test mode entered", int'(test_mode), 1);
        repeat (PH1 + PH2L + 10) begin
            @(negedge clk);
            if (!test_mode || spi_resp_en || accel_valid || fuse_pwr_en || !init_busy) leaked++;
        end
        chk(leaked == 0, "R2 test mode held", leaked, 0);
        set_sup(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(internal_rst && !test_mode, "R9 reset from test mode", int'(test_mode), 0);
        prog_hv = 1'b0;
        set_sup(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        report();
    end

    initial begin
        t_reset();
        t_supply_gate();
        t_normal_short();
        t_drop_normal();
        t_hpf_long();
        t_drop_normal();
        t_slow_fuse();
        t_drop_normal();
        t_drop_midway();
        t_test_mode();
        repeat (4) @(negedge clk);
        report();
    end

endmodule